// File: doc/BRIEF.md
# Processor Status Word Unit with Exception Save Slots

This block keeps the live status word of a processor core: the four ALU condition flags, a sticky saturation flag, the two interrupt mask bits, the instruction-state bit and the five-bit operating-mode field. It also keeps one saved copy of that word for each of the five exception modes. User and System modes have no saved copy. When an exception is taken, the live word is copied into the saved slot of the mode being entered. In the same edge the mode switches, the normal-interrupt mask is set and the instruction-state bit is cleared. Entering fast-interrupt mode also sets the fast-interrupt mask. A return strobe reloads the live word from the saved slot of the current mode.

The two active-low request pins are first synchronised. A request counts as recognised only after its pin has been seen low on two clock edges in a row. A recognised request is then gated by its mask bit before it leaves the block. Flag updates from the ALU arrive as a write strobe with four flag values, plus a separate strobe that sets the saturation flag.

Top module: `proc_status`

## Requirements
- R1: An active-low reset (`rstN`) does the following. The live word becomes 0x000000D3: Supervisor mode, both masks set, all flags and T clear. Every saved slot becomes 0x00000010. `irqReq` and `fiqReq` are low.
- R2: The word layout is N=31, Z=30, C=29, V=28, Q=27, I=7, F=6, T=5 and mode=[4:0], and all other bits read zero. Mode codes: User 0x10, Fast 0x11, Normal-IRQ 0x12, Supervisor 0x13, Abort 0x17, Undefined 0x1B, System 0x1F. `curMode` always equals bits [4:0].
- R3: Entry happens when `excEnter` is high and `excMode` is one of the five exception codes. At the next edge, the prior live word is stored in the slot of `excMode`. The mode becomes `excMode`, I becomes 1 and T becomes 0. N, Z, C, V and Q keep their values, and any flag, saturation or return strobe in that cycle has no effect.
- R4: Entering the Fast mode sets F. Entering any other exception mode leaves F unchanged.
- R5: An entry strobe whose `excMode` is not an exception code (including User and System) has no effect. The other strobes in that cycle act as if it were absent.
- R6: `excRet` without a valid entry reloads the whole live word from the slot of the current mode. In User or System mode it leaves the word unchanged. Each exception mode has its own slot, so nested entries unwind in order.
- R7: `flagWe` writes `flagIn` as {N,Z,C,V} when no entry or restore happens in that cycle. `satSet` sets Q under the same condition. A flag write does not clear Q. Only a restore can clear Q.
- R8: `irqReq` is high only when a normal request is recognised and I=0. `fiqReq` is high only when a fast request is recognised and F=0. A mask change takes effect in the cycle the word changes.
- R9: A request is recognised when its pin was low at the last two clock edges. A pin that is low for only one edge produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flagWe | input | 1 | Write strobe for the condition flags |
| flagIn | input | 4 | New flag values {N,Z,C,V} |
| satSet | input | 1 | Sets the sticky saturation flag |
| excEnter | input | 1 | Exception-entry strobe |
| excMode | input | 5 | Mode code of the exception being entered |
| excRet | input | 1 | Exception-return strobe |
| irqPinN | input | 1 | Active-low normal interrupt request pin |
| fiqPinN | input | 1 | Active-low fast interrupt request pin |
| statusWord | output | 32 | Live status word |
| irqReq | output | 1 | Recognised and unmasked normal request |
| fiqReq | output | 1 | Recognised and unmasked fast request |
| curMode | output | 5 | Current mode field |

## Verification
The assertions assume that strobes and pins are driven to known 0/1 values whenever reset is released. They also assume that a return is only meaningful after the matching slot has been written or reset.

The stimulus changes inputs shortly after each rising edge and releases reset between sweep passes, so every property starts from a known word. The sweep covers all 32 possible entry codes, so the invalid-code behaviour is exercised as fully as the valid entries. Request pins are held low for counted numbers of edges, one or two, so each recognition window is deliberate rather than incidental.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int WORD_W    = 32;
  localparam int MODE_W    = 5;
  localparam int NUM_SLOTS = 5;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

  localparam logic [WORD_W-1:0] SLOT_RESET = 32'h0000_0010;

  typedef struct packed {
    logic              doEnter;
    logic              doReturn;
    logic              doFlags;
    logic              doSat;
    logic              setFast;
    logic [SLOT_W-1:0] entSlot;
    logic [SLOT_W-1:0] retSlot;
  } ctrl_t;

  function automatic logic hasSlot(input logic [MODE_W-1:0] m);
    return (m == MODE_FIQ) || (m == MODE_IRQ) || (m == MODE_SVC) ||
           (m == MODE_ABT) || (m == MODE_UND);
  endfunction

  function automatic logic [SLOT_W-1:0] slotOf(input logic [MODE_W-1:0] m);
    logic [SLOT_W-1:0] s;
    case (m)
      MODE_FIQ: s = SLOT_W'(0);
      MODE_IRQ: s = SLOT_W'(1);
      MODE_SVC: s = SLOT_W'(2);
      MODE_ABT: s = SLOT_W'(3);
      MODE_UND: s = SLOT_W'(4);
      default:  s = SLOT_W'(0);
    endcase
    return s;
  endfunction
endpackage

// File: rtl/stat_sync.sv
module stat_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinN,
  output logic seenLow
);
  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[DEPTH-2:0], pinN};
  end

  assign seenLow = ~|chain;

  p_recognise_r9: assert property (@(posedge clk) disable iff (!rstN)
    seenLow |-> !$past(pinN));
endmodule

// File: rtl/stat_ctrl.sv
module stat_ctrl
  import stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              flagWe,
  input  logic              satSet,
  input  logic              excEnter,
  input  logic [MODE_W-1:0] excMode,
  input  logic              excRet,
  input  logic [MODE_W-1:0] curMode,
  output ctrl_t             ctl
);
  logic entOk;
  logic retOk;

  assign entOk = excEnter && hasSlot(excMode);
  assign retOk = !entOk && excRet && hasSlot(curMode);

  always_comb begin
    ctl          = '0;
    ctl.doEnter  = entOk;
    ctl.doReturn = retOk;
    ctl.doFlags  = !entOk && !retOk && flagWe;
    ctl.doSat    = !entOk && !retOk && satSet;
    ctl.setFast  = entOk && (excMode == MODE_FIQ);
    ctl.entSlot  = slotOf(excMode);
    ctl.retSlot  = slotOf(curMode);
  end

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.doEnter, ctl.doReturn, ctl.doFlags || ctl.doSat}));
endmodule

// File: rtl/stat_dp.sv
module stat_dp
  import stat_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [3:0]        flagIn,
  input  logic [MODE_W-1:0] excMode,
  input  logic              irqPinN,
  input  logic              fiqPinN,
  output logic [WORD_W-1:0] statusWord,
  output logic              irqReq,
  output logic              fiqReq
);
  logic nFlag, zFlag, cFlag, vFlag, qFlag;
  logic iMask, fMask, tBit;
  logic [MODE_W-1:0] modeReg;
  logic [WORD_W-1:0] savedWord [NUM_SLOTS];
  logic [WORD_W-1:0] restoreWord;
  logic irqSeen, fiqSeen;

  assign statusWord = {nFlag, zFlag, cFlag, vFlag, qFlag, 19'b0,
                       iMask, fMask, tBit, modeReg};

  always_comb begin
    restoreWord = SLOT_RESET;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (ctl.retSlot == SLOT_W'(k)) restoreWord = savedWord[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {nFlag, zFlag, cFlag, vFlag, qFlag} <= '0;
      iMask   <= 1'b1;
      fMask   <= 1'b1;
      tBit    <= 1'b0;
      modeReg <= MODE_SVC;
    end else if (ctl.doEnter) begin
      modeReg <= excMode;
      iMask   <= 1'b1;
      tBit    <= 1'b0;
      if (ctl.setFast) fMask <= 1'b1;
    end else if (ctl.doReturn) begin
      {nFlag, zFlag, cFlag, vFlag, qFlag} <= restoreWord[31:27];
      iMask   <= restoreWord[7];
      fMask   <= restoreWord[6];
      tBit    <= restoreWord[5];
      modeReg <= restoreWord[4:0];
    end else begin
      if (ctl.doFlags) {nFlag, zFlag, cFlag, vFlag} <= flagIn;
      if (ctl.doSat)   qFlag <= 1'b1;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        savedWord[s] <= SLOT_RESET;
      else if (ctl.doEnter && ctl.entSlot == SLOT_W'(s))
        savedWord[s] <= statusWord;
    end
  end

  stat_sync #(.DEPTH(SYNC_DEPTH)) u_irqSync (
    .clk(clk), .rstN(rstN), .pinN(irqPinN), .seenLow(irqSeen));
  stat_sync #(.DEPTH(SYNC_DEPTH)) u_fiqSync (
    .clk(clk), .rstN(rstN), .pinN(fiqPinN), .seenLow(fiqSeen));

  assign irqReq = irqSeen && !iMask;
  assign fiqReq = fiqSeen && !fMask;

  p_entry_mode_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doEnter |=> (modeReg == $past(excMode)) && iMask && !tBit);
  p_fast_masks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doEnter && excMode == MODE_FIQ) |=> fMask);
  p_other_f_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doEnter && excMode != MODE_FIQ) |=> $stable(fMask));
  p_q_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(qFlag) |-> $past(ctl.doReturn));
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> !statusWord[7]);
  p_fiq_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    fiqReq |-> !statusWord[6]);
endmodule

// File: rtl/proc_status.sv
module proc_status
  import stat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flagWe,
  input  logic [3:0]  flagIn,
  input  logic        satSet,
  input  logic        excEnter,
  input  logic [4:0]  excMode,
  input  logic        excRet,
  input  logic        irqPinN,
  input  logic        fiqPinN,
  output logic [31:0] statusWord,
  output logic        irqReq,
  output logic        fiqReq,
  output logic [4:0]  curMode
);
  ctrl_t ctl;

  assign curMode = statusWord[4:0];

  stat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .flagWe(flagWe), .satSet(satSet),
    .excEnter(excEnter), .excMode(excMode), .excRet(excRet),
    .curMode(curMode), .ctl(ctl));

  stat_dp #(.SYNC_DEPTH(2)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .flagIn(flagIn), .excMode(excMode),
    .irqPinN(irqPinN), .fiqPinN(fiqPinN), .statusWord(statusWord),
    .irqReq(irqReq), .fiqReq(fiqReq));

  p_user_ret_r6: assert property (@(posedge clk) disable iff (!rstN)
    (excRet && !excEnter && !flagWe && !satSet &&
     (curMode == MODE_USR || curMode == MODE_SYS)) |=> $stable(statusWord));
  p_bad_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (excEnter && !hasSlot(excMode) && !excRet && !flagWe && !satSet)
      |=> $stable(statusWord));
endmodule

// File: tb/proc_status_test.sv
`timescale 1ns/1ps
module proc_status_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flagWe = 0, satSet = 0, excEnter = 0, excRet = 0;
  logic [3:0] flagIn = '0;
  logic [4:0] excMode = '0;
  logic irqPinN = 1, fiqPinN = 1;
  logic [31:0] statusWord;
  logic irqReq, fiqReq;
  logic [4:0] curMode;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  proc_status uut (.*);

  function automatic logic isExc(input logic [4:0] m);
    return m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B;
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] nzcv, input logic q,
      input logic i, input logic f, input logic t, input logic [4:0] m);
    return (32'(nzcv) << 28) | (32'(q) << 27) | (32'(i) << 7) |
           (32'(f) << 6) | (32'(t) << 5) | 32'(m);
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    flagWe = 0; satSet = 0; excEnter = 0; excRet = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
  endtask

  task automatic enter(input logic [4:0] m);
    excEnter = 1; excMode = m; step();
  endtask

  task automatic leave();
    excRet = 1; step();
  endtask

  task automatic setFlags(input logic [3:0] v);
    flagWe = 1; flagIn = v; step();
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] base;
    logic [31:0] exp;
    doReset();
    check("R1 reset word", statusWord, 32'h0000_00D3);
    check("R2 mode port", 32'(curMode), 32'h13);
    check("R1 reqs low", {30'b0, irqReq, fiqReq}, 32'h0);

    // R8: masked at reset, pins low for several edges
    irqPinN = 0; fiqPinN = 0;
    repeat (3) @(posedge clk); #1;
    check("R8 masked after reset", {30'b0, irqReq, fiqReq}, 32'h0);
    irqPinN = 1; fiqPinN = 1;
    repeat (3) @(posedge clk); #1;

    // R1/R6: reset slot content restored from Supervisor
    leave();
    check("R6 restore reset slot", statusWord, 32'h0000_0010);

    // Sweep every entry code (R3, R4, R5, R6)
    for (int c = 0; c < 32; c++) begin
      logic [3:0] p;
      logic [4:0] m;
      p = 4'(c) ^ 4'hA;
      m = 5'(c);
      doReset();
      leave();
      setFlags(p);
      base = mk(p, 0, 0, 0, 0, 5'h10);
      enter(m);
      exp = isExc(m) ? mk(p, 0, 1, (m == 5'h11), 0, m) : base;
      check(isExc(m) ? "R3 R4 entry" : "R5 bad entry", statusWord, exp);
      check("R2 curMode", 32'(curMode), {27'b0, exp[4:0]});
      leave();
      check(isExc(m) ? "R6 restore" : "R6 user return ignored", statusWord, base);
    end

    // R9 / R8 recognition from User mode
    doReset(); leave();
    irqPinN = 0;
    @(posedge clk); #1;
    check("R9 one edge low", {31'b0, irqReq}, 32'h0);
    @(posedge clk); #1;
    check("R9 two edges low", {31'b0, irqReq}, 32'h1);
    irqPinN = 1;
    @(posedge clk); #1;
    check("R9 release", {31'b0, irqReq}, 32'h0);
    fiqPinN = 0;
    @(posedge clk); #1;
    fiqPinN = 1;
    repeat (3) begin
      @(posedge clk); #1;
      check("R9 single-edge pulse", {31'b0, fiqReq}, 32'h0);
    end
    irqPinN = 0; fiqPinN = 0;
    repeat (2) @(posedge clk); #1;
    check("R8 both unmasked", {30'b0, irqReq, fiqReq}, 32'h3);
    enter(5'h12);
    check("R8 irq masked in IRQ mode", {30'b0, irqReq, fiqReq}, 32'h1);
    enter(5'h11);
    check("R8 both masked in fast mode", {30'b0, irqReq, fiqReq}, 32'h0);
    // R6 nested unwind
    leave();
    check("R6 unwind to IRQ", statusWord, mk(0, 0, 1, 0, 0, 5'h12));
    leave();
    check("R6 unwind to User", statusWord, 32'h10);
    check("R8 unmasked again", {30'b0, irqReq, fiqReq}, 32'h3);
    irqPinN = 1; fiqPinN = 1;

    // R7 flags and sticky Q
    setFlags(4'hF);
    satSet = 1; step();
    check("R7 sat set", statusWord, mk(4'hF, 1, 0, 0, 0, 5'h10));
    setFlags(4'h0);
    check("R7 flag write keeps Q", statusWord, mk(4'h0, 1, 0, 0, 0, 5'h10));
    flagWe = 1; flagIn = 4'h5; satSet = 1; excRet = 1; step();
    check("R7 strobes in User return", statusWord, mk(4'h5, 1, 0, 0, 0, 5'h10));
    doReset(); leave();
    enter(5'h17);
    satSet = 1; step();
    check("R7 Q set in Abort", statusWord, mk(0, 1, 1, 0, 0, 5'h17));
    leave();
    check("R7 restore clears Q", statusWord, 32'h10);

    // R3: flag strobe ignored during entry; R6: entry wins over return
    flagWe = 1; flagIn = 4'h9; excEnter = 1; excMode = 5'h1B; step();
    check("R3 flags ignored on entry", statusWord, mk(0, 0, 1, 0, 0, 5'h1B));
    excEnter = 1; excMode = 5'h13; excRet = 1; step();
    check("R6 entry beats return", statusWord, mk(0, 0, 1, 0, 0, 5'h13));
    leave();
    check("R6 supervisor slot", statusWord, mk(0, 0, 1, 0, 0, 5'h1B));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule